// File: doc/BRIEF.md
# Inter-Processor Mailbox

This block lets a local processor and a remote processor trade 32-bit tagged messages through two independent one-way queues of eight entries each. The inbound queue takes words pushed by the remote side, and the local processor drains it over a small 32-bit register bus. The outbound queue takes words the local processor writes over the bus, and the remote side drains them.

Each message keeps a 4-bit channel number in bits 3:0 and a 28-bit payload in bits 31:4. The block passes all 32 bits through unchanged. Each inbound entry also stores a 2-bit tag that names the sender. The local side can pop the head of the inbound queue or look at it without popping. It can read each queue's status word and enable a level interrupt that stays high while inbound data waits.

The bus is combinational on reads: `bus_rdata` reflects `bus_addr` in the cycle that `bus_rd` is high. A pop or push takes effect at the next rising clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty and both status words read 0x40000000. The configuration register reads 0 and `irq` is low.
- R2: A status word carries the full flag in bit 31, the empty flag in bit 30 and the entry count in its low bits. A partly filled queue reads 0x00000001 to 0x00000007, and a full queue reads 0x80000008. Inbound status is at offset 0x18 and outbound status at 0x38.
- R3: A read at offset 0x00 returns the oldest inbound message with all 32 bits intact (channel in bits 3:0, payload in bits 31:4) and removes it. Messages leave in the order they arrived.
- R4: A read at offset 0x10 returns the oldest inbound message and leaves the queue and its count unchanged.
- R5: A read at offset 0x14 returns the 2-bit sender tag of the oldest inbound entry in bits 1:0, with all other bits zero. It returns zero when the inbound queue is empty.
- R6: A write at offset 0x20 appends the word to the outbound queue. The remote side sees words on `rem_pop_data` in write order, and `rem_empty` is high when nothing waits.
- R7: Boundary cases behave as follows:
  - A read at 0x00 or 0x10 with the inbound queue empty returns zero and changes nothing.
  - A write at 0x20 with the outbound queue full is discarded.
  - A remote push with the inbound queue full is discarded, and `rem_full` is high while that queue is full.
- R8: Bit 0 of the configuration register at 0x1C is writable and readable, and its other bits read zero. `irq` equals that bit ANDed with the inbound queue being non-empty. `irq` falls at the clock edge that pops the last inbound entry.
- R9: Traffic in one direction never changes the other direction's status word. For example, filling the outbound queue leaves inbound status at 0x40000000.
- R10: Reads of any offset outside 0x00, 0x10, 0x14, 0x18, 0x1C and 0x38 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_rd | input | 1 | Read strobe; a read at 0x00 pops at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt for inbound data |
| rem_push | input | 1 | Remote side pushes a word into the inbound queue |
| rem_push_data | input | 32 | Word pushed by the remote side |
| rem_push_id | input | 2 | Sender tag stored with the pushed word |
| rem_full | output | 1 | Inbound queue is full |
| rem_pop | input | 1 | Remote side takes the head of the outbound queue |
| rem_pop_data | output | 32 | Head of the outbound queue, zero when empty |
| rem_empty | output | 1 | Outbound queue is empty |

## Verification
A wrong count or pointer appears on the next status or data read. A count that drifts shows up in the status word in the same cycle it is read. A read pointer that slips returns a message out of order, or a message that was already consumed, at the following pop or peek. The sender tag is stored beside the data, so a misaligned tag appears at offset 0x14 on the first read after the fault. An enable or count fault moves `irq` away from the bench's expected level within one cycle of the access that caused it.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int SW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  input  logic          rem_push,
  input  logic [31:0]   rem_push_data,
  input  logic [SW-1:0] rem_push_id,
  output logic          rem_full,
  input  logic          rem_pop,
  output logic [31:0]   rem_pop_data,
  output logic          rem_empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] A_POP  = AW'('h00);
  localparam logic [AW-1:0] A_PEEK = AW'('h10);
  localparam logic [AW-1:0] A_SID  = AW'('h14);
  localparam logic [AW-1:0] A_IST  = AW'('h18);
  localparam logic [AW-1:0] A_CFG  = AW'('h1C);
  localparam logic [AW-1:0] A_PUSH = AW'('h20);
  localparam logic [AW-1:0] A_OST  = AW'('h38);

  logic [31:0]   in_mem  [DEPTH];
  logic [SW-1:0] in_tag  [DEPTH];
  logic [31:0]   out_mem [DEPTH];
  logic [PW-1:0] in_wp, in_rp, out_wp, out_rp;
  logic [CW-1:0] in_cnt, out_cnt;
  logic          cfg_en;

  wire in_full   = in_cnt  == CW'(DEPTH);
  wire in_empty  = in_cnt  == '0;
  wire out_full  = out_cnt == CW'(DEPTH);
  wire out_empty = out_cnt == '0;

  wire in_push  = rem_push & ~in_full;
  wire in_pop   = bus_rd & (bus_addr == A_POP) & ~in_empty;
  wire out_push = bus_wr & (bus_addr == A_PUSH) & ~out_full;
  wire out_pop  = rem_pop & ~out_empty;

  wire [31:0] in_head = in_empty ? 32'd0 : in_mem[in_rp];

  assign rem_full     = in_full;
  assign rem_empty    = out_empty;
  assign rem_pop_data = out_empty ? 32'd0 : out_mem[out_rp];
  assign irq          = cfg_en & ~in_empty;

  always_ff @(posedge clk) begin
    if (in_push) begin
      in_mem[in_wp] <= rem_push_data;
      in_tag[in_wp] <= rem_push_id;
    end
    if (out_push) out_mem[out_wp] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_wp <= '0; in_rp <= '0; in_cnt <= '0;
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
      cfg_en <= 1'b0;
    end else begin
      if (in_push)  in_wp  <= in_wp + 1'b1;
      if (in_pop)   in_rp  <= in_rp + 1'b1;
      if (out_push) out_wp <= out_wp + 1'b1;
      if (out_pop)  out_rp <= out_rp + 1'b1;
      in_cnt  <= in_cnt  + CW'(in_push)  - CW'(in_pop);
      out_cnt <= out_cnt + CW'(out_push) - CW'(out_pop);
      if (bus_wr && bus_addr == A_CFG) cfg_en <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_rd) begin
      case (bus_addr)
        A_POP, A_PEEK: bus_rdata = in_head;
        A_SID:  bus_rdata = in_empty ? 32'd0 : {{(32-SW){1'b0}}, in_tag[in_rp]};
        A_IST:  bus_rdata = {in_full, in_empty, {(30-CW){1'b0}}, in_cnt};
        A_CFG:  bus_rdata = {31'd0, cfg_en};
        A_OST:  bus_rdata = {out_full, out_empty, {(30-CW){1'b0}}, out_cnt};
        default: bus_rdata = 32'd0;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt <= CW'(DEPTH)) && (out_cnt <= CW'(DEPTH)));

  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_full && bus_wr && bus_addr == A_PUSH && !rem_pop) |=> out_full && $stable(out_wp));

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_empty && bus_rd && bus_addr == A_POP && !rem_push) |=> in_empty && $stable(in_rp));

  p_peek_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_PEEK && !rem_push) |=> $stable(in_cnt) && $stable(in_rp));

  p_irq_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt == CW'(1) && bus_rd && bus_addr == A_POP && !rem_push) |=> !irq);

  p_inbound_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rem_push && !(bus_rd && bus_addr == A_POP)) |=> $stable(in_cnt));

  p_outbound_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rem_pop && !(bus_wr && bus_addr == A_PUSH)) |=> $stable(out_cnt));
endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rem_push = 1'b0;
  logic [31:0] rem_push_data = '0;
  logic [1:0]  rem_push_id = '0;
  logic        rem_full;
  logic        rem_pop = 1'b0;
  logic [31:0] rem_pop_data;
  logic        rem_empty;

  int checks = 0, fails = 0;
  logic [31:0] q_in[$];
  logic [1:0]  q_tag[$];
  logic [31:0] q_out[$];
  logic        m_en = 1'b0;

  always #4 clk = ~clk;

  ipc_mailbox uut (.*);

  function automatic logic [31:0] st(int n);
    return {n == 8, n == 0, 26'd0, 4'(n)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic check_irq();
    @(negedge clk);
    check("R8 irq", {31'd0, irq}, {31'd0, m_en && q_in.size() != 0});
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
    if (a == 8'h20 && q_out.size() < 8) q_out.push_back(d);
    if (a == 8'h1C) m_en = d[0];
  endtask

  task automatic rpush(logic [31:0] d, logic [1:0] t);
    @(negedge clk);
    rem_push_data = d; rem_push_id = t; rem_push = 1'b1;
    @(posedge clk); #1 rem_push = 1'b0;
    if (q_in.size() < 8) begin q_in.push_back(d); q_tag.push_back(t); end
  endtask

  task automatic rpop(output logic [31:0] d);
    @(negedge clk);
    rem_pop = 1'b1;
    #1 d = rem_pop_data;
    @(posedge clk); #1 rem_pop = 1'b0;
  endtask

  task automatic exp_pop(string req);
    logic [31:0] d;
    rd(8'h00, d);
    if (q_in.size() == 0) check(req, d, 32'd0);
    else begin check(req, d, q_in.pop_front()); void'(q_tag.pop_front()); end
  endtask

  task automatic exp_rpop(string req);
    logic [31:0] d;
    rpop(d);
    if (q_out.size() == 0) check(req, d, 32'd0);
    else check(req, d, q_out.pop_front());
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(8'h18, d); check("R1 inbound status", d, 32'h40000000);
    rd(8'h38, d); check("R1 outbound status", d, 32'h40000000);
    rd(8'h1C, d); check("R1 cfg", d, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    rd(8'h00, d); check("R7 empty pop", d, 32'd0);
    rd(8'h10, d); check("R7 empty peek", d, 32'd0);
    rd(8'h14, d); check("R5 empty sender", d, 32'd0);
    rd(8'h18, d); check("R7 status after empty pop", d, 32'h40000000);

    for (int i = 0; i < 9; i++) begin
      wr(8'h20, 32'hA0000000 + 32'(i * 16 + 3));
      rd(8'h38, d); check("R2 outbound count", d, st(i < 8 ? i + 1 : 8));
      rd(8'h18, d); check("R9 inbound untouched", d, 32'h40000000);
    end
    check("R6 rem_empty low", {31'd0, rem_empty}, 32'd0);
    for (int i = 0; i < 9; i++) exp_rpop("R6 outbound order");
    check("R6 rem_empty high", {31'd0, rem_empty}, 32'd1);

    wr(8'h1C, 32'hFFFFFFFF);
    rd(8'h1C, d); check("R8 cfg readback", d, 32'd1);
    check_irq();
    for (int i = 0; i < 9; i++) begin
      rpush({28'(i + 100), 4'(i)}, 2'(i));
      rd(8'h18, d); check("R2 inbound count", d, st(i < 8 ? i + 1 : 8));
      rd(8'h38, d); check("R9 outbound untouched", d, 32'h40000000);
    end
    check("R7 rem_full", {31'd0, rem_full}, 32'd1);
    check_irq();
    rd(8'h10, d); check("R4 peek head", d, q_in[0]);
    rd(8'h18, d); check("R4 peek keeps count", d, st(8));
    rd(8'h14, d); check("R5 sender tag", d, {30'd0, q_tag[0]});
    for (int i = 0; i < 8; i++) begin
      exp_pop("R3 inbound order");
      check_irq();
    end
    rd(8'h18, d); check("R3 drained", d, 32'h40000000);

    rd(8'h04, d); check("R10 unmapped 04", d, 32'd0);
    rd(8'h3C, d); check("R10 unmapped 3C", d, 32'd0);
    rd(8'hFF, d); check("R10 unmapped FF", d, 32'd0);

    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 8);
      case (op)
        0, 1: rpush($urandom(), 2'($urandom_range(0, 3)));
        2: exp_pop("R3 random pop");
        3: begin
          rd(8'h10, d);
          check("R4 random peek", d, q_in.size() ? q_in[0] : 32'd0);
        end
        4: begin
          rd(8'h14, d);
          check("R5 random sender", d, q_in.size() ? {30'd0, q_tag[0]} : 32'd0);
        end
        5: wr(8'h20, $urandom());
        6: exp_rpop("R6 random remote pop");
        7: begin
          rd(8'h18, d); check("R2 random inbound status", d, st(q_in.size()));
          rd(8'h38, d); check("R2 random outbound status", d, st(q_out.size()));
        end
        default: wr(8'h1C, {31'd0, 1'($urandom_range(0, 1))});
      endcase
      check_irq();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule